// File: doc/BRIEF.md
# Modulator-Aware Deadbeat Duty Calculator

This block computes the duty word for a two-level, single-leg inverter that feeds a resistive-inductive load with a back-EMF. On each modulator sample strobe it predicts the duty needed to bring the load current to its reference by the end of the coming carrier half-period. The prediction accounts for the fact that the two switching states are applied in a fixed order within that half-period. The order depends on whether the carrier is rising or falling.

The datapath works entirely in signed fixed point. A one-pole low-pass filter runs at the clock rate on the measured current. The reference is extrapolated one sample ahead from its last three values. The back-EMF contribution is estimated by inverting the previous sample's plant prediction, so it needs no tuning. Because the two states always differ by 2, the solve step needs no divider: it multiplies by a precomputed reciprocal `coef_k` = 1/(2·b1). The result is clamped, turned into the fraction of time the positive state is applied, and presented with a one-cycle valid pulse.

Top module: `deadbeat_duty`

## Requirements
- R1: After a synchronous active-low reset, `duty` is 0 and `duty_valid` is 0. The current filter, the two-deep reference history, the previous filtered current and the stored previous average state are all zero, and no earlier sample is counted as present.
- R2: A strobe sampled high at clock edge E0 updates `duty` and raises `duty_valid` at edge E0+2. `duty_valid` is high for exactly that one cycle, and `duty` does not change while `duty_valid` is low. Strobes must be at least 3 cycles apart.
- R3: The predicted reference is x = 3·r0 − 3·r1 + r2. Here r0 is `i_ref` at the strobe, and r1 and r2 are the references at the previous two strobes (zero if absent since reset).
- R4: The filter state f updates every clock as f ← f + i_meas − floor(f / 2^FILT_SHIFT) (default FILT_SHIFT = 2). The filtered current y = floor(f / 2^FILT_SHIFT) is taken as its value at the strobe edge.
- R5: On the first strobe after reset the back-EMF term e is 0. On later strobes e = y − floor(a·y_prev / 2^14) − floor(b1·s_prev / 2^11), where y_prev is the filtered current at the previous strobe and s_prev is the stored average state.
- R6: With n0 = x − floor(a·y / 2^14) − e, the numerator is n0 + b1 for a falling carrier (`carrier_rising` = 0) and b1 − n0 for a rising carrier. p = floor(num·k / 2^13). `coef_a` is signed Q.14, `coef_b1` is a signed integer in current LSBs, and `coef_k` is unsigned Q0.24.
- R7: p is clamped to the range [0, 2048], where 2048 represents 1.0.
- R8: For a falling carrier `duty` = p. For a rising carrier `duty` = 2048 − p. `duty` is therefore the fraction of the half-period spent in the positive state.
- R9: When `duty` updates, the stored previous average state becomes 2·duty − 2048. This value is used in R5 at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle modulator sample strobe |
| carrier_rising | input | 1 | 1 = carrier rising at this sample, 0 = falling |
| i_meas | input | 16 | Measured current, signed LSBs |
| i_ref | input | 16 | Current reference sample, signed LSBs |
| coef_a | input | 18 | Plant factor a, signed Q.14 |
| coef_b1 | input | 16 | Plant factor b1, signed, current LSBs per unit state |
| coef_k | input | 24 | 1/(2·b1), unsigned Q0.24 |
| duty | output | 12 | Positive-state duty, 2048 = 1.0 |
| duty_valid | output | 1 | One-cycle pulse marking a new duty |

## Verification
Every duty result falls due exactly two edges after the edge that samples the strobe. Each scenario therefore raises the strobe at a falling edge and then samples at the next three falling edges. It expects `duty_valid` low, low, then high with the computed duty, and one further falling edge later it expects the pulse gone and the duty held. The reference model tracks the filter state edge by edge. It reads the filtered current at the falling edge just before the strobe edge, which is the value the datapath latches. Saturation, direction, first-sample and post-reset cases each use the same timing, so a result that arrives one cycle early or late fails at a named sample point.

// File: rtl/dbd_pkg.sv
// Shared definitions for the deadbeat duty calculator.
// Assumes: nothing beyond IEEE 1800-2017.
package dbd_pkg;
    // Carrier slope at the sample instant; selects the first-applied state.
    typedef enum logic {
        CARR_FALL = 1'b0,
        CARR_RISE = 1'b1
    } carr_dir_e;

    // Guard bits added above the current width in summed datapath terms.
    localparam int HEADROOM_BITS = 6;
endpackage

// File: rtl/dbd_cur_filter.sv
// One-pole low-pass on the measured current, updated every clock.
// Keeps FILT_SHIFT extra fraction bits so a constant input is reached exactly.
// Assumes: i_meas is a signed sample valid on every clock.
module dbd_cur_filter #(
    parameter int CUR_W      = 16,
    parameter int FILT_SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CUR_W-1:0] i_meas,
    output logic signed [CUR_W-1:0] y
);
    localparam int AF = CUR_W + FILT_SHIFT + 1;

    logic signed [AF-1:0] acc;

    // Leaky accumulator: acc moves by the input minus its own scaled output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc + AF'(i_meas) - (acc >>> FILT_SHIFT);
        end
    end

    assign y = CUR_W'(acc >>> FILT_SHIFT);
endmodule

// File: rtl/dbd_ref_extrap.sv
// Second-order extrapolation of the reference one sample ahead.
// Assumes: i_ref is valid in the cycle sample_stb is high.
module dbd_ref_extrap #(
    parameter int CUR_W = 16,
    parameter int ACC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic signed [CUR_W-1:0] i_ref,
    output logic signed [ACC_W-1:0] ext_q
);
    logic signed [CUR_W-1:0] hist1;
    logic signed [CUR_W-1:0] hist2;
    logic signed [ACC_W-1:0] ext_d;

    // Predicted reference from the last three samples.
    always_comb begin
        ext_d = ACC_W'(i_ref) * 3 - ACC_W'(hist1) * 3 + ACC_W'(hist2);
    end

    // Latch prediction and shift the reference history on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist2 <= '0;
            ext_q <= '0;
        end else if (stb) begin
            ext_q <= ext_d;
            hist1 <= i_ref;
            hist2 <= hist1;
        end
    end

    // R3
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (hist1 == $past(i_ref)) && (hist2 == $past(hist1)));
endmodule

// File: rtl/dbd_emf_est.sv
// Back-EMF term (b2 times vemf) found by inverting the previous prediction:
// whatever the plant did beyond a*y_prev + b1*s_prev is attributed to it.
// Assumes: back-EMF changes slowly against the sample rate; s_prev is
// already updated for the previous sample when the next strobe arrives.
module dbd_emf_est #(
    parameter int CUR_W     = 16,
    parameter int COEF_W    = 18,
    parameter int COEF_FRAC = 14,
    parameter int DUTY_W    = 12,
    parameter int ACC_W     = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [CUR_W-1:0]  y,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [CUR_W-1:0]  coef_b1,
    input  logic signed [DUTY_W:0]   s_prev,
    output logic signed [ACC_W-1:0]  emf_q
);
    localparam int DUTY_FRAC = DUTY_W - 1;
    localparam int AYW       = COEF_W + CUR_W;
    localparam int BW        = CUR_W + DUTY_W + 1;

    logic signed [CUR_W-1:0] y_prev;
    logic                    have_prev;
    logic signed [AYW-1:0]   prod_a;
    logic signed [BW-1:0]    prod_b;
    logic signed [ACC_W-1:0] emf_d;

    // Residual of the previous step's prediction.
    always_comb begin
        prod_a = coef_a * y_prev;
        prod_b = coef_b1 * s_prev;
        emf_d  = ACC_W'(y) - ACC_W'(prod_a >>> COEF_FRAC)
                 - ACC_W'(prod_b >>> DUTY_FRAC);
    end

    // Register the estimate; zero until a previous sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_prev    <= '0;
            have_prev <= 1'b0;
            emf_q     <= '0;
        end else if (stb) begin
            emf_q     <= have_prev ? emf_d : '0;
            y_prev    <= y;
            have_prev <= 1'b1;
        end
    end

    // R5
    first_emf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !have_prev) |=> (emf_q == '0));
endmodule

// File: rtl/dbd_duty_solve.sv
// Solves for the duty of the first-applied state, clamps it and converts it
// to the positive-state fraction. Three register stages from the strobe.
// Assumes: coefficients static; coef_k = 1/(2*b1); strobes >= 3 cycles apart.
module dbd_duty_solve
    import dbd_pkg::*;
#(
    parameter int CUR_W     = 16,
    parameter int COEF_W    = 18,
    parameter int COEF_FRAC = 14,
    parameter int K_W       = 24,
    parameter int K_FRAC    = 24,
    parameter int DUTY_W    = 12,
    parameter int ACC_W     = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  carr_dir_e                dir,
    input  logic signed [CUR_W-1:0]  y,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [CUR_W-1:0]  coef_b1,
    input  logic        [K_W-1:0]    coef_k,
    input  logic signed [ACC_W-1:0]  ext_q,
    input  logic signed [ACC_W-1:0]  emf_q,
    output logic        [DUTY_W-1:0] duty,
    output logic                     duty_valid,
    output logic signed [DUTY_W:0]   s_avg
);
    localparam int DUTY_FRAC = DUTY_W - 1;
    localparam int ONE       = 1 << DUTY_FRAC;
    localparam int SH        = K_FRAC - DUTY_FRAC;
    localparam int PW        = ACC_W + K_W + 1;
    localparam int AYW       = COEF_W + CUR_W;
    localparam logic signed [PW-1:0] ONE_W = PW'(ONE);

    logic signed [CUR_W-1:0]  y_q;
    carr_dir_e                dir_q;
    carr_dir_e                dir2;
    logic                     v1;
    logic                     v2;
    logic signed [AYW-1:0]    prod_ay;
    logic signed [ACC_W-1:0]  n0;
    logic signed [ACC_W-1:0]  num_d;
    logic signed [ACC_W-1:0]  num_q;
    logic signed [PW-1:0]     prod_k;
    logic signed [PW-1:0]     p_full;
    logic        [DUTY_W-1:0] p_sat;
    logic        [DUTY_W-1:0] duty_n;
    logic signed [DUTY_W+1:0] twice;

    // Stage 1: capture the filtered current and carrier slope at the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q   <= '0;
            dir_q <= CARR_FALL;
            v1    <= 1'b0;
        end else begin
            v1 <= stb;
            if (stb) begin
                y_q   <= y;
                dir_q <= dir;
            end
        end
    end

    // Numerator with the ordered-state offset, sign flipped for rising carrier.
    always_comb begin
        prod_ay = coef_a * y_q;
        n0      = ext_q - ACC_W'(prod_ay >>> COEF_FRAC) - emf_q;
        if (dir_q == CARR_RISE) begin
            num_d = ACC_W'(coef_b1) - n0;
        end else begin
            num_d = n0 + ACC_W'(coef_b1);
        end
    end

    // Stage 2: hold the numerator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            dir2  <= CARR_FALL;
            v2    <= 1'b0;
        end else begin
            v2 <= v1;
            if (v1) begin
                num_q <= num_d;
                dir2  <= dir_q;
            end
        end
    end

    // Reciprocal multiply, clamp, and conversion to positive-state fraction.
    always_comb begin
        prod_k = num_q * $signed({1'b0, coef_k});
        p_full = prod_k >>> SH;
        if (p_full < 0) begin
            p_sat = '0;
        end else if (p_full > ONE_W) begin
            p_sat = DUTY_W'(ONE);
        end else begin
            p_sat = DUTY_W'(p_full);
        end
        duty_n = (dir2 == CARR_RISE) ? DUTY_W'(ONE) - p_sat : p_sat;
        twice  = $signed({1'b0, duty_n, 1'b0});
    end

    // Stage 3: publish duty, valid pulse and the applied average state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty       <= '0;
            duty_valid <= 1'b0;
            s_avg      <= '0;
        end else begin
            duty_valid <= v2;
            if (v2) begin
                duty  <= duty_n;
                s_avg <= (DUTY_W+1)'(twice - (DUTY_W+2)'(ONE));
            end
        end
    end

    // R7
    duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty <= DUTY_W'(ONE));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> $past(stb, 3));

    // R2
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_valid |-> $stable(duty));

    // R9
    avg_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> (s_avg == (DUTY_W+1)'(2 * int'(duty) - ONE)));
endmodule

// File: rtl/deadbeat_duty.sv
// Top of the modulator-aware deadbeat duty calculator: filter, reference
// extrapolation, back-EMF estimation and duty solve, wired around a strobe.
// Assumes: synchronous active-low reset; strobes at least 3 cycles apart;
// coefficients held constant while running.
module deadbeat_duty
    import dbd_pkg::*;
#(
    parameter int CUR_W      = 16,
    parameter int COEF_W     = 18,
    parameter int COEF_FRAC  = 14,
    parameter int K_W        = 24,
    parameter int K_FRAC     = 24,
    parameter int DUTY_W     = 12,
    parameter int FILT_SHIFT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     carrier_rising,
    input  logic signed [CUR_W-1:0]  i_meas,
    input  logic signed [CUR_W-1:0]  i_ref,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [CUR_W-1:0]  coef_b1,
    input  logic        [K_W-1:0]    coef_k,
    output logic        [DUTY_W-1:0] duty,
    output logic                     duty_valid
);
    localparam int ACC_W = CUR_W + HEADROOM_BITS;

    carr_dir_e               dir_in;
    logic signed [CUR_W-1:0] y_f;
    logic signed [ACC_W-1:0] ext_q;
    logic signed [ACC_W-1:0] emf_q;
    logic signed [DUTY_W:0]  s_avg;

    assign dir_in = carrier_rising ? CARR_RISE : CARR_FALL;

    dbd_cur_filter #(.CUR_W(CUR_W), .FILT_SHIFT(FILT_SHIFT)) u_filt (
        .clk(clk), .rst_n(rst_n), .i_meas(i_meas), .y(y_f)
    );

    dbd_ref_extrap #(.CUR_W(CUR_W), .ACC_W(ACC_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .stb(sample_stb), .i_ref(i_ref), .ext_q(ext_q)
    );

    dbd_emf_est #(
        .CUR_W(CUR_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
        .DUTY_W(DUTY_W), .ACC_W(ACC_W)
    ) u_emf (
        .clk(clk), .rst_n(rst_n), .stb(sample_stb), .y(y_f),
        .coef_a(coef_a), .coef_b1(coef_b1), .s_prev(s_avg), .emf_q(emf_q)
    );

    dbd_duty_solve #(
        .CUR_W(CUR_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
        .K_W(K_W), .K_FRAC(K_FRAC), .DUTY_W(DUTY_W), .ACC_W(ACC_W)
    ) u_solve (
        .clk(clk), .rst_n(rst_n), .stb(sample_stb), .dir(dir_in), .y(y_f),
        .coef_a(coef_a), .coef_b1(coef_b1), .coef_k(coef_k),
        .ext_q(ext_q), .emf_q(emf_q),
        .duty(duty), .duty_valid(duty_valid), .s_avg(s_avg)
    );
endmodule

// File: tb/deadbeat_duty_tb_top.sv
`timescale 1ns/1ps
// Directed bench for deadbeat_duty: one task per scenario, each self-checked
// against an integer model built from the requirements.
module deadbeat_duty_tb_top;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               sample_stb;
    logic               carrier_rising;
    logic signed [15:0] i_meas;
    logic signed [15:0] i_ref;
    logic signed [17:0] coef_a;
    logic signed [15:0] coef_b1;
    logic        [23:0] coef_k;
    logic        [11:0] duty;
    logic               duty_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    longint m_acc;
    longint m_r1, m_r2, m_yprev, m_sprev;
    bit     m_have;

    always #2.5 clk = ~clk;

    deadbeat_duty dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .carrier_rising(carrier_rising), .i_meas(i_meas), .i_ref(i_ref),
        .coef_a(coef_a), .coef_b1(coef_b1), .coef_k(coef_k),
        .duty(duty), .duty_valid(duty_valid)
    );

    // R4 model of the filter state, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) m_acc <= 0;
        else        m_acc <= m_acc + longint'(i_meas) - (m_acc >>> 2);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_r1 = 0; m_r2 = 0; m_yprev = 0; m_sprev = 0; m_have = 0;
    endtask

    // One strobe with model prediction and timing checks (R2 on every call).
    task automatic sample(input longint r, input bit rise, input string req,
                          output int exp_out);
        longint y, ext, ay, e, n0, num, p;
        int d;
        @(negedge clk);
        y   = m_acc >>> 2;
        ext = 3 * r - 3 * m_r1 + m_r2;
        ay  = (longint'(coef_a) * y) >>> 14;
        e   = m_have ? (y - ((longint'(coef_a) * m_yprev) >>> 14)
                          - ((longint'(coef_b1) * m_sprev) >>> 11)) : 0;
        n0  = ext - ay - e;
        num = rise ? (longint'(coef_b1) - n0) : (n0 + longint'(coef_b1));
        p   = (num * longint'(coef_k)) >>> 13;
        if (p < 0) p = 0;
        if (p > 2048) p = 2048;
        d = rise ? int'(2048 - p) : int'(p);
        m_r2 = m_r1; m_r1 = r; m_yprev = y; m_sprev = 2 * d - 2048; m_have = 1;
        i_ref = 16'(r);
        carrier_rising = rise;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check(duty_valid == 1'b0, "R2", "valid after strobe edge", duty_valid, 0);
        @(negedge clk);
        check(duty_valid == 1'b0, "R2", "valid one edge later", duty_valid, 0);
        @(negedge clk);
        check(duty_valid == 1'b1, "R2", "valid at second edge", duty_valid, 1);
        check(int'(duty) == d, req, "duty", duty, d);
        @(negedge clk);
        check(duty_valid == 1'b0, "R2", "valid pulse width", duty_valid, 0);
        check(int'(duty) == d, "R2", "duty held", duty, d);
        exp_out = d;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(duty == 12'd0, "R1", "duty after reset", duty, 0);
        check(duty_valid == 1'b0, "R1", "valid after reset", duty_valid, 0);
    endtask

    task automatic t_first_sample();
        int d;
        i_meas = 16'sd0;
        repeat (4) @(negedge clk);
        sample(20, 1'b0, "R3 R5 R6 R8 first", d);
        check(int'(duty) == 1264, "R6", "first falling duty literal", duty, 1264);
    endtask

    task automatic t_emf_rising();
        int d;
        i_meas = 16'sd40;
        repeat (60) @(negedge clk);
        sample(24, 1'b1, "R5 R8 R9", d);
        check(int'(duty) == 1032, "R9", "estimate from stored state", duty, 1032);
    endtask

    task automatic t_ramp();
        int d;
        sample(30, 1'b0, "R3 R6 ramp", d);
        sample(36, 1'b1, "R3 R8 ramp", d);
        sample(42, 1'b0, "R3 R6 ramp", d);
    endtask

    task automatic t_saturation();
        int d;
        sample(3000, 1'b0, "R7 high", d);
        check(int'(duty) == 2048, "R7", "upper clamp", duty, 2048);
        sample(-3000, 1'b1, "R7 R8 rising", d);
        check(int'(duty) == 0, "R7", "clamp then complement", duty, 0);
    endtask

    task automatic t_filter_lag();
        int d;
        @(negedge clk);
        i_meas = 16'sd400;
        sample(40, 1'b0, "R4 partial filter", d);
        repeat (3) @(negedge clk);
        sample(40, 1'b1, "R4 filter later", d);
    endtask

    task automatic t_reset_again();
        int d;
        i_meas = 16'sd0;
        do_reset();
        check(duty == 12'd0, "R1", "duty after second reset", duty, 0);
        sample(10, 1'b0, "R1 R3 R5 cleared history", d);
        check(int'(duty) == 1144, "R1", "history cleared literal", duty, 1144);
    endtask

    initial begin
        rst_n = 1'b0;
        sample_stb = 1'b0;
        carrier_rising = 1'b0;
        i_meas = 16'sd0;
        i_ref = 16'sd0;
        coef_a = 18'sd12288;
        coef_b1 = 16'sd256;
        coef_k = 24'd32768;
        t_reset_state();
        t_first_sample();
        t_emf_rising();
        t_ramp();
        t_saturation();
        t_filter_lag();
        t_reset_again();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule